// File: doc/BRIEF.md
# Serial Page Address Sequencer

This block produces a continuous column address stream for a memory run in a serial page mode. A programming command arms the mode. An activate command then names the first bank and row, and a following read or write command names the start column. From the clock after that column command, the block presents one address per enabled clock. The column counts up. When the top column of a page has been sent, the stream moves to the next bank and the next row, and it starts again at the original start column, not at column zero.

The stream runs until an all-bank precharge is accepted. All other commands received while a row is open or a stream is running are refused and reported on a single-cycle violation strobe. The same strobe reports two spacing rules that the block checks with its own counter. A clock-enable input freezes the whole block.

Top module: `serial_page_seq`

## Requirements
- R1: After a synchronous reset, `out_valid`, `violation` and `serial_armed` are 0.
- R2: A mode command (cmd 5) is accepted only while no row is open. It sets `serial_armed` when `cmd_addr[2:0]` is 3'b110, `cmd_addr[3]` is 0 and `cmd_addr[9]` is 0. Any other value clears it. An activate (cmd 1) while disarmed is ignored and raises no violation.
- R3: An accepted activate latches the bank from `cmd_bank` (0 = A, 1 = B, 2 = C, 3 = D) and the row from `cmd_addr`. A read (cmd 2) or write (cmd 3) that follows it latches the start column from `cmd_addr[7:0]`. On the next cycle `out_valid` is 1, the outputs show that bank, row and start column, and `out_write` is 1 only for a write.
- R4: While streaming, the column rises by one on every enabled clock.
- R5: After the last column (255) the next address uses bank+1 (A, B, C, D, then A again), row+1 and the start column.
- R6: The row wraps from 1535 to 0 on a page crossing.
- R7: A precharge (cmd 4) with `cmd_addr[10]`=1, received at least 6 enabled clocks after the accepted activate, ends the stream. `out_valid` is 0 on the next cycle.
- R8: While a row is open or streaming, the following commands raise `violation` for one cycle and leave the stream unchanged: a single-bank precharge (`cmd_addr[10]`=0), an activate, a mode command, and a read or write once streaming has begun.
- R9: An all-bank precharge received fewer than 6 enabled clocks after the accepted activate raises `violation` and is ignored.
- R10: An activate received fewer than 9 enabled clocks after an accepted all-bank precharge raises `violation` and is ignored. At 9 or more clocks it is accepted.
- R11: While `cke` is 0, every output holds its value and the command inputs are ignored.
- R12: A read or write received while no row is open raises `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable. When low, the block is frozen |
| cmd | input | 3 | Command code: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 mode |
| cmd_bank | input | 2 | Bank for an activate |
| cmd_addr | input | 11 | Row, start column, all-bank flag (bit 10) or mode value |
| out_valid | output | 1 | The stream address is valid |
| out_bank | output | 2 | Current bank |
| out_row | output | 11 | Current row |
| out_col | output | 8 | Current column |
| out_write | output | 1 | The stream was started by a write |
| serial_armed | output | 1 | Serial page mode is programmed |
| violation | output | 1 | One-cycle pulse for an illegal or early command |

## Verification
Two cases are hard to reach from the ports. The first is a bank crossing from D back to A, which also increments the row. The second is a row wrap from 1535 to 0. The stimulus starts one stream at bank C with start column 250, so two page crossings occur within about a dozen clocks. It starts a second stream at bank B, row 1535, column 255, so every step crosses a page and the row wraps at once. The spacing rules are probed with early precharge and early activate commands. The accepted retry and the stream that follows show that the counter restarted at the correct point.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_MRS = 3'd5
  } sps_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OPEN   = 2'd1,
    ST_STREAM = 2'd2
  } sps_state_e;
endpackage

// File: rtl/sps_mode_reg.sv
module sps_mode_reg #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] value,
  output logic          armed
);
  localparam int          BL_LSB  = 0;
  localparam int          BT_BIT  = 3;
  localparam int          WBL_BIT = 9;
  localparam logic [2:0]  BL_SERIAL = 3'b110;

  logic match;
  assign match = (value[BL_LSB +: 3] == BL_SERIAL) && !value[BT_BIT] && !value[WBL_BIT];

  always_ff @(posedge clk) begin
    if (rst)     armed <= 1'b0;
    else if (we) armed <= match;
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(armed));
endmodule

// File: rtl/sps_gap_timer.sv
module sps_gap_timer #(
  parameter int T_A = 6,
  parameter int T_B = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic ok_a,
  output logic ok_b
);
  localparam int CNT_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= CW'(CNT_MAX);
    else if (en && clr)              cnt <= CW'(1);
    else if (en && cnt < CW'(CNT_MAX)) cnt <= cnt + 1'b1;
  end

  assign ok_a = (cnt >= CW'(T_A));
  assign ok_b = (cnt >= CW'(T_B));

  // R9
  gap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (en && clr && T_A > 1) |=> !ok_a);
endmodule

// File: rtl/sps_addr_gen.sv
module sps_addr_gen #(
  parameter int BANKS = 4,
  parameter int ROWS  = 1536,
  parameter int COLS  = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_row,
  input  logic [$clog2(BANKS)-1:0] row_bank,
  input  logic [$clog2(ROWS)-1:0]  row_addr,
  input  logic                     load_col,
  input  logic [$clog2(COLS)-1:0]  col_start,
  input  logic                     step,
  output logic [$clog2(BANKS)-1:0] bank,
  output logic [$clog2(ROWS)-1:0]  row,
  output logic [$clog2(COLS)-1:0]  col
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(BANKS - 1);

  logic [COL_W-1:0] start;
  logic             page_end;
  assign page_end = (col == COL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank  <= '0;
      row   <= '0;
      col   <= '0;
      start <= '0;
    end else if (load_row) begin
      bank <= row_bank;
      row  <= row_addr;
    end else if (load_col) begin
      col   <= col_start;
      start <= col_start;
    end else if (step) begin
      if (page_end) begin
        col  <= start;
        bank <= (bank == BANK_LAST) ? '0 : bank + 1'b1;
        row  <= (row == ROW_LAST) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load_row && !load_col && !page_end) |=> (col == $past(col) + 1'b1) && $stable(bank));
  // R5
  page_cross_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load_row && !load_col && page_end) |=> (col == $past(start)) && (bank != $past(bank)));
  // R6
  row_range_chk: assert property (@(posedge clk) disable iff (rst)
    row <= ROW_LAST);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_row || load_col || step) |=> $stable(col) && $stable(row) && $stable(bank));
endmodule

// File: rtl/serial_page_seq.sv
module serial_page_seq
  import sps_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int ROWS      = 1536,
  parameter int COLS      = 256,
  parameter int ADDR_W    = 11,
  parameter int T_ACT_PRE = 6,
  parameter int T_PRE_ACT = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cke,
  input  logic [2:0]               cmd,
  input  logic [$clog2(BANKS)-1:0] cmd_bank,
  input  logic [ADDR_W-1:0]        cmd_addr,
  output logic                     out_valid,
  output logic [$clog2(BANKS)-1:0] out_bank,
  output logic [$clog2(ROWS)-1:0]  out_row,
  output logic [$clog2(COLS)-1:0]  out_col,
  output logic                     out_write,
  output logic                     serial_armed,
  output logic                     violation
);
  localparam int ROW_W   = $clog2(ROWS);
  localparam int COL_W   = $clog2(COLS);
  localparam int ALL_BIT = ADDR_W - 1;

  sps_cmd_e   cmd_e;
  sps_state_e state, nxt_state;
  logic ld_row, ld_col, stop, illegal, mrs_we, clr, step;
  logic ras_ok, rp_ok, all_bank;

  assign cmd_e    = sps_cmd_e'(cmd);
  assign all_bank = cmd_addr[ALL_BIT];

  always_comb begin
    nxt_state = state;
    ld_row    = 1'b0;
    ld_col    = 1'b0;
    stop      = 1'b0;
    illegal   = 1'b0;
    mrs_we    = 1'b0;
    clr       = 1'b0;
    if (cke) begin
      unique case (state)
        ST_IDLE: begin
          case (cmd_e)
            CMD_ACT: if (serial_armed) begin
              if (rp_ok) begin
                ld_row    = 1'b1;
                clr       = 1'b1;
                nxt_state = ST_OPEN;
              end else illegal = 1'b1;
            end
            CMD_RD, CMD_WR: illegal = 1'b1;
            CMD_MRS:        mrs_we  = 1'b1;
            default: ;
          endcase
        end
        default: begin
          case (cmd_e)
            CMD_RD, CMD_WR: begin
              if (state == ST_OPEN) begin
                ld_col    = 1'b1;
                nxt_state = ST_STREAM;
              end else illegal = 1'b1;
            end
            CMD_ACT, CMD_MRS: illegal = 1'b1;
            CMD_PRE: begin
              if (all_bank && ras_ok) begin
                stop      = 1'b1;
                clr       = 1'b1;
                nxt_state = ST_IDLE;
              end else illegal = 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  assign step = cke && (state == ST_STREAM) && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      out_valid <= 1'b0;
      out_write <= 1'b0;
      violation <= 1'b0;
    end else begin
      state     <= nxt_state;
      out_valid <= (nxt_state == ST_STREAM);
      violation <= illegal;
      if (ld_col) out_write <= (cmd_e == CMD_WR);
    end
  end

  sps_mode_reg #(.AW(ADDR_W)) mode_i (
    .clk(clk), .rst(rst), .we(mrs_we), .value(cmd_addr), .armed(serial_armed)
  );

  sps_gap_timer #(.T_A(T_ACT_PRE), .T_B(T_PRE_ACT)) gap_i (
    .clk(clk), .rst(rst), .en(cke), .clr(clr), .ok_a(ras_ok), .ok_b(rp_ok)
  );

  sps_addr_gen #(.BANKS(BANKS), .ROWS(ROWS), .COLS(COLS)) addr_i (
    .clk(clk), .rst(rst),
    .load_row(ld_row), .row_bank(cmd_bank), .row_addr(cmd_addr[ROW_W-1:0]),
    .load_col(ld_col), .col_start(cmd_addr[COL_W-1:0]),
    .step(step),
    .bank(out_bank), .row(out_row), .col(out_col)
  );

  // R11
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |=> $stable(out_valid) && $stable(out_write) && !violation);
  // R3
  stream_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(cmd_e == CMD_RD || cmd_e == CMD_WR));
  // R7
  stream_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(cmd_e == CMD_PRE && all_bank));
endmodule

// File: tb/serial_page_seq_tb_top.sv
module serial_page_seq_tb_top;
  localparam int CLK_P = 10;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, MRS = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic [2:0]  cmd = NOP;
  logic [1:0]  cmd_bank = '0;
  logic [10:0] cmd_addr = '0;
  logic        out_valid, out_write, serial_armed, violation;
  logic [1:0]  out_bank;
  logic [10:0] out_row;
  logic [7:0]  out_col;

  always #(CLK_P/2) clk = ~clk;

  serial_page_seq dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .out_valid(out_valid), .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
    .out_write(out_write), .serial_armed(serial_armed), .violation(violation)
  );

  typedef struct {
    int          due;
    logic        valid;
    logic [1:0]  bank;
    logic [10:0] row;
    logic [7:0]  col;
    logic        wr;
    logic        viol;
    logic        armed;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // reference state built from the requirements
  int          m_state = 0;
  int          m_since = 100;
  logic        m_armed = 0, m_wr = 0, m_viol = 0;
  logic [1:0]  m_bank = 0;
  logic [10:0] m_row = 0;
  logic [7:0]  m_col = 0, m_start = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input logic [2:0] c, input logic [1:0] b, input logic [10:0] a,
                      input logic ke, input string tag);
    exp_t e;
    bit   was_stream;
    @(negedge clk);
    cmd = c; cmd_bank = b; cmd_addr = a; cke = ke;
    m_viol = 0;
    if (ke) begin
      m_since++;
      was_stream = (m_state == 2);
      case (c)
        ACT: if (m_state == 0) begin
               if (m_armed) begin
                 if (m_since >= 9) begin m_bank = b; m_row = a; m_state = 1; m_since = 0; end
                 else m_viol = 1;
               end
             end else m_viol = 1;
        RD, WR: if (m_state == 1) begin
                  m_col = a[7:0]; m_start = a[7:0]; m_wr = (c == WR); m_state = 2;
                end else m_viol = 1;
        PRE: if (m_state != 0) begin
               if (a[10] && m_since >= 6) begin m_state = 0; m_since = 0; end
               else m_viol = 1;
             end
        MRS: if (m_state == 0) m_armed = (a[2:0] == 3'b110) && !a[3] && !a[9];
             else m_viol = 1;
        default: ;
      endcase
      if (was_stream && m_state == 2) begin
        if (m_col == 8'd255) begin
          m_col  = m_start;
          m_bank = m_bank + 2'd1;
          m_row  = (m_row == 11'd1535) ? 11'd0 : m_row + 11'd1;
        end else m_col = m_col + 8'd1;
      end
    end
    e.due = cyc + 1; e.valid = (m_state == 2); e.bank = m_bank; e.row = m_row;
    e.col = m_col; e.wr = m_wr; e.viol = m_viol; e.armed = m_armed; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      bit   bad;
      e = q.pop_front();
      checks++;
      bad = (out_valid !== e.valid) || (violation !== e.viol) || (serial_armed !== e.armed);
      if (e.valid)
        bad = bad || (out_bank !== e.bank) || (out_row !== e.row) ||
              (out_col !== e.col) || (out_write !== e.wr);
      if (bad) begin
        errors++;
        $display("FAIL %s: got v=%b b=%0d r=%0d c=%0d w=%b viol=%b arm=%b exp v=%b b=%0d r=%0d c=%0d w=%b viol=%b arm=%b",
          e.tag, out_valid, out_bank, out_row, out_col, out_write, violation, serial_armed,
          e.valid, e.bank, e.row, e.col, e.wr, e.viol, e.armed);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick(NOP, 0, 0, 1, "R1");
    tick(ACT, 2, 11'd5, 1, "R2");          // disarmed: ignored
    tick(RD, 0, 11'd250, 1, "R12");        // no row open
    tick(MRS, 0, 11'h00E, 1, "R2");        // burst type 1: stays disarmed
    tick(MRS, 0, 11'h206, 1, "R2");        // write burst bit set: disarmed
    tick(MRS, 0, 11'h006, 1, "R2");        // armed
    tick(ACT, 2, 11'd5, 1, "R3");
    tick(NOP, 0, 0, 1, "R9");
    tick(PRE, 0, 11'h400, 1, "R9");        // too early
    tick(RD, 0, 11'd250, 1, "R3");
    repeat (3) tick(NOP, 0, 0, 1, "R4");
    tick(PRE, 0, 11'h000, 1, "R8");        // single bank precharge
    tick(NOP, 0, 0, 1, "R4");
    tick(NOP, 0, 0, 1, "R5");              // C -> D, row 6
    tick(ACT, 0, 11'd9, 1, "R8");
    tick(WR, 0, 11'd3, 1, "R8");
    tick(MRS, 0, 11'h006, 1, "R8");
    tick(NOP, 0, 0, 0, "R11");
    tick(PRE, 0, 11'h400, 0, "R11");
    tick(NOP, 0, 0, 0, "R11");
    repeat (8) tick(NOP, 0, 0, 1, "R5");   // D -> A, row 7
    tick(PRE, 0, 11'h400, 1, "R7");
    tick(NOP, 0, 0, 1, "R7");
    tick(ACT, 1, 11'd1535, 1, "R10");      // too early
    repeat (7) tick(NOP, 0, 0, 1, "R10");
    tick(ACT, 1, 11'd1535, 1, "R10");      // accepted
    tick(WR, 0, 11'd255, 1, "R6");
    tick(NOP, 0, 0, 1, "R6");              // row wraps to 0
    tick(NOP, 0, 0, 1, "R6");
    tick(PRE, 0, 11'h400, 1, "R9");        // fewer than 6 since activate
    repeat (3) tick(NOP, 0, 0, 1, "R5");
    tick(PRE, 0, 11'h400, 1, "R7");
    tick(NOP, 0, 0, 1, "R7");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule